// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This block holds the condition code register of a small 8-bit processor datapath and decides, each cycle, which flags to rewrite. The datapath supplies an operation class code, the ALU result (8 or 16 bits wide) and the carry, overflow and half-carry signals the ALU produced. Each class writes its own subset of flags. Every flag outside that subset keeps its value. For compare and test operations the ALU presents the result of the implied subtraction; this block only derives flags from it, and nothing is written back.

The block also owns the maskable-interrupt mask bit. Reset forces the mask on. The sequencer's one-cycle strobes then move it. A stacking-done strobe sets it when an interrupt is taken. Explicit set and clear strobes move it under program control. A restore strobe reloads the whole register from a saved byte when an interrupt returns. A combinational gate combines the mask with a pending request and an instruction-boundary indication to accept a maskable interrupt.

Flag layout in `flags`: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 interrupt mask, bit 5 half-carry. Bits 6 and 7 are spare: only a restore writes them.

Top module: `ccr_unit`

## Requirements
- R1: After reset, `flags` reads 0x10: the mask (bit 4) is 1 and every other bit is 0.
- R2: When a class writes Z, bit 2 is 1 exactly when the result is zero. For narrow ops (`wideOp`=0) only bits 7:0 are tested. For wide ops all 16 bits are tested.
- R3: When a class writes N, bit 3 takes result bit 7 for narrow ops and result bit 15 for wide ops.
- R4: Class 1 (add type) writes H (bit 5), N, Z, V and C from the result, `aluHalf`, `aluOvf` and `aluCarry`.
- R5: Class 2 (subtract, compare, test) writes N, Z, V and C. H and the spare bits are held.
- R6: Class 3 (logic and data move) writes N and Z, clears V, and holds C and H.
- R7: Class 4 (index increment or decrement) writes Z only. All other flags are held.
- R8: Class 5 (shift and rotate) writes N, Z, V and C. H is held.
- R9: With `opValid` low, or with an unused class code (0, 6, 7), no arithmetic flag changes.
- R10: A `stackDone` strobe sets the mask bit at the next clock edge.
- R11: `maskSet` sets the mask. `maskClr` clears it. When both are high, set wins. The mask falls only on `maskClr` or a restore. No operation class changes the mask.
- R12: A `restoreValid` strobe loads all 8 bits from `restoreValue` at the next edge. It overrides every other update in the same cycle.
- R13: `irqAccept` is high exactly when `irqPending` and `instrBoundary` are both high and the mask bit is 0. It is combinational within the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation completes this cycle |
| opClass | input | 3 | Operation class code |
| wideOp | input | 1 | Result is 16 bits wide |
| aluResult | input | 16 | ALU result (low byte for narrow ops) |
| aluCarry | input | 1 | ALU carry/borrow out |
| aluOvf | input | 1 | ALU signed overflow |
| aluHalf | input | 1 | Carry from bit 3 into bit 4 |
| maskSet | input | 1 | Explicit set-mask strobe |
| maskClr | input | 1 | Explicit clear-mask strobe |
| stackDone | input | 1 | Interrupt stacking finished strobe |
| restoreValid | input | 1 | Restore-from-stack strobe |
| restoreValue | input | 8 | Saved flag byte |
| irqPending | input | 1 | Maskable request pending |
| instrBoundary | input | 1 | Current cycle is an instruction boundary |
| irqAccept | output | 1 | Maskable interrupt accepted |
| flags | output | 8 | Condition code register |

## Verification
On every cycle, the assertions check four rules. An index operation changes nothing but Z (and the mask, if a mask strobe arrives in the same cycle). Non-add classes hold H. A stacking strobe always leaves the mask set. The mask never falls without a clear or restore strobe, and a restore lands exactly. The values written into Z, N, V and C, the 8-bit versus 16-bit selection, the set-over-clear priority and the acceptance gate can only be shown by the bench's directed scenarios. Those scenarios compare the whole register against an expected byte after each step.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int FLAG_W = 8;
  localparam int C_BIT  = 0;
  localparam int V_BIT  = 1;
  localparam int Z_BIT  = 2;
  localparam int N_BIT  = 3;
  localparam int I_BIT  = 4;
  localparam int H_BIT  = 5;

  localparam logic [FLAG_W-1:0] RESET_FLAGS = FLAG_W'(1) << I_BIT;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_LOGIC = 3'd3,
    OP_IDX   = 3'd4,
    OP_SHIFT = 3'd5
  } opClass_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic wrC;
    logic wrV;
    logic clrV;
    logic wrZ;
    logic wrN;
    logic wrH;
    logic setI;
    logic clrI;
    logic loadAll;
  } flagStrobe_t;

endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opClass,
  input  logic        maskSet,
  input  logic        maskClr,
  input  logic        stackDone,
  input  logic        restoreValid,
  input  logic        irqPending,
  input  logic        instrBoundary,
  input  logic        maskBit,
  output flagStrobe_t strobe,
  output logic        irqAccept
);

  always_comb begin
    strobe = '0;
    if (opValid) begin
      case (opClass_e'(opClass))
        OP_ADD: begin
          strobe.wrH = 1'b1;
          strobe.wrN = 1'b1;
          strobe.wrZ = 1'b1;
          strobe.wrV = 1'b1;
          strobe.wrC = 1'b1;
        end
        OP_SUB, OP_SHIFT: begin
          strobe.wrN = 1'b1;
          strobe.wrZ = 1'b1;
          strobe.wrV = 1'b1;
          strobe.wrC = 1'b1;
        end
        OP_LOGIC: begin
          strobe.wrN  = 1'b1;
          strobe.wrZ  = 1'b1;
          strobe.clrV = 1'b1;
        end
        OP_IDX:  strobe.wrZ = 1'b1;
        default: ;
      endcase
    end
    // set has priority over clear; restore overrides all in the datapath
    strobe.setI    = maskSet | stackDone;
    strobe.clrI    = maskClr & ~strobe.setI;
    strobe.loadAll = restoreValid;
  end

  assign irqAccept = irqPending & instrBoundary & ~maskBit;

  // R10: interrupt entry leaves the mask set
  p_entry_sets_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stackDone && !restoreValid) |=> maskBit);

endmodule

// File: rtl/ccr_dpath.sv
module ccr_dpath
  import ccr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic              wideOp,
  input  logic [DATA_W-1:0] result,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              halfIn,
  input  logic [FLAG_W-1:0] restoreValue,
  output logic [FLAG_W-1:0] flagsQ
);

  localparam int WIDE_MSB   = DATA_W - 1;
  localparam int NARROW_MSB = NARROW_W - 1;

  logic              zeroDet;
  logic              negDet;
  logic [FLAG_W-1:0] flagsD;

  assign zeroDet = wideOp ? (result == '0) : (result[NARROW_MSB:0] == '0);
  assign negDet  = wideOp ? result[WIDE_MSB] : result[NARROW_MSB];

  always_comb begin
    flagsD = flagsQ;
    if (strobe.wrC)  flagsD[C_BIT] = carryIn;
    if (strobe.wrV)  flagsD[V_BIT] = ovfIn;
    if (strobe.clrV) flagsD[V_BIT] = 1'b0;
    if (strobe.wrZ)  flagsD[Z_BIT] = zeroDet;
    if (strobe.wrN)  flagsD[N_BIT] = negDet;
    if (strobe.wrH)  flagsD[H_BIT] = halfIn;
    if (strobe.setI)      flagsD[I_BIT] = 1'b1;
    else if (strobe.clrI) flagsD[I_BIT] = 1'b0;
    if (strobe.loadAll) flagsD = restoreValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= RESET_FLAGS;
    else       flagsQ <= flagsD;
  end

  // R11: mask falls only after a clear or restore strobe
  p_mask_fall_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagsQ[I_BIT]) |-> $past(strobe.clrI || strobe.loadAll));

  // R12: restore lands the saved byte exactly
  p_restore_exact_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAll |=> (flagsQ == $past(restoreValue)));

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opClass,
  input  logic              wideOp,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOvf,
  input  logic              aluHalf,
  input  logic              maskSet,
  input  logic              maskClr,
  input  logic              stackDone,
  input  logic              restoreValid,
  input  logic [7:0]        restoreValue,
  input  logic              irqPending,
  input  logic              instrBoundary,
  output logic              irqAccept,
  output logic [7:0]        flags
);

  localparam logic [FLAG_W-1:0] IDX_FREE = (FLAG_W'(1) << Z_BIT) | (FLAG_W'(1) << I_BIT);

  flagStrobe_t strobe;

  ccr_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .opValid      (opValid),
    .opClass      (opClass),
    .maskSet      (maskSet),
    .maskClr      (maskClr),
    .stackDone    (stackDone),
    .restoreValid (restoreValid),
    .irqPending   (irqPending),
    .instrBoundary(instrBoundary),
    .maskBit      (flags[I_BIT]),
    .strobe       (strobe),
    .irqAccept    (irqAccept)
  );

  ccr_dpath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wideOp       (wideOp),
    .result       (aluResult),
    .carryIn      (aluCarry),
    .ovfIn        (aluOvf),
    .halfIn       (aluHalf),
    .restoreValue (restoreValue),
    .flagsQ       (flags)
  );

  // R7: index ops change nothing but Z (mask strobes may act alongside)
  p_idx_only_z_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == OP_IDX && !restoreValid) |=>
      (((flags ^ $past(flags)) & ~IDX_FREE) == '0));

  // R5: classes other than add hold H
  p_h_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opClass != OP_ADD && !restoreValid) |=> $stable(flags[H_BIT]));

endmodule

// File: tb/ccr_unit_tb_top.sv
`timescale 1ns/1ps
module ccr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid, wideOp, aluCarry, aluOvf, aluHalf;
  logic [2:0]  opClass;
  logic [15:0] aluResult;
  logic        maskSet, maskClr, stackDone, restoreValid;
  logic [7:0]  restoreValue;
  logic        irqPending, instrBoundary;
  logic        irqAccept;
  logic [7:0]  flags;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ccr_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .wideOp(wideOp), .aluResult(aluResult), .aluCarry(aluCarry),
    .aluOvf(aluOvf), .aluHalf(aluHalf), .maskSet(maskSet),
    .maskClr(maskClr), .stackDone(stackDone), .restoreValid(restoreValid),
    .restoreValue(restoreValue), .irqPending(irqPending),
    .instrBoundary(instrBoundary), .irqAccept(irqAccept), .flags(flags)
  );

  task automatic idleInputs();
    opValid = 0; opClass = 3'd0; wideOp = 0; aluResult = '0;
    aluCarry = 0; aluOvf = 0; aluHalf = 0; maskSet = 0; maskClr = 0;
    stackDone = 0; restoreValid = 0; restoreValue = '0;
    irqPending = 0; instrBoundary = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("[TB] FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, clear and return
  task automatic doOp(input logic [2:0] c, input logic w, input logic [15:0] r,
                      input logic cy, input logic v, input logic h);
    @(negedge clk);
    opValid = 1; opClass = c; wideOp = w; aluResult = r;
    aluCarry = cy; aluOvf = v; aluHalf = h;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic pulseMask(input logic s, input logic c, input logic st);
    @(negedge clk);
    maskSet = s; maskClr = c; stackDone = st;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic testReset();
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset value", flags, 8'h10);
    irqPending = 1; instrBoundary = 1; #1;
    chk("R13 masked request blocked", {7'd0, irqAccept}, 8'h00);
    idleInputs();
  endtask

  task automatic testMaskAndGate();
    pulseMask(0, 1, 0);
    chk("R11 clear mask", flags, 8'h00);
    irqPending = 1; instrBoundary = 0; #1;
    chk("R13 no boundary", {7'd0, irqAccept}, 8'h00);
    instrBoundary = 1; #1;
    chk("R13 accepted", {7'd0, irqAccept}, 8'h01);
    idleInputs();
  endtask

  task automatic testArith();
    doOp(3'd1, 0, 16'h0000, 1, 0, 1);
    chk("R4 add zero with carry and half", flags, 8'h25);
    doOp(3'd4, 1, 16'h0100, 1, 1, 0);
    chk("R7 R2 wide index nonzero", flags, 8'h21);
    doOp(3'd4, 1, 16'h0000, 0, 0, 0);
    chk("R7 R2 wide index zero", flags, 8'h25);
    doOp(3'd2, 0, 16'h0080, 0, 1, 0);
    chk("R5 R3 compare negative", flags, 8'h2A);
    doOp(3'd3, 1, 16'h8000, 1, 1, 0);
    chk("R6 R3 wide logic negative", flags, 8'h28);
    doOp(3'd3, 0, 16'h8000, 0, 0, 0);
    chk("R6 R2 narrow ignores upper byte", flags, 8'h24);
    doOp(3'd5, 0, 16'h0001, 1, 1, 0);
    chk("R8 shift", flags, 8'h23);
    @(negedge clk);
    opValid = 0; opClass = 3'd1; aluResult = 16'h0000; aluCarry = 0; aluOvf = 0; aluHalf = 0;
    @(negedge clk);
    idleInputs();
    chk("R9 invalid op holds", flags, 8'h23);
    doOp(3'd7, 0, 16'h0000, 0, 0, 1);
    chk("R9 unused class holds", flags, 8'h23);
    doOp(3'd1, 0, 16'h0010, 0, 0, 0);
    chk("R4 add clears flags", flags, 8'h00);
  endtask

  task automatic testMaskRules();
    pulseMask(0, 0, 1);
    chk("R10 stacking sets mask", flags, 8'h10);
    doOp(3'd1, 0, 16'h0010, 0, 0, 0);
    chk("R11 op leaves mask", flags, 8'h10);
    pulseMask(0, 1, 0);
    chk("R11 clear again", flags, 8'h00);
    pulseMask(1, 1, 0);
    chk("R11 set wins over clear", flags, 8'h10);
  endtask

  task automatic testRestore();
    @(negedge clk);
    restoreValid = 1; restoreValue = 8'hC5; stackDone = 1; maskSet = 1;
    opValid = 1; opClass = 3'd1; aluResult = 16'h0080; aluCarry = 0; aluHalf = 1;
    @(negedge clk);
    idleInputs();
    chk("R12 restore overrides", flags, 8'hC5);
    doOp(3'd4, 0, 16'h0001, 0, 0, 1);
    chk("R7 spare bits held", flags, 8'hC1);
  endtask

  initial begin
    testReset();
    testMaskAndGate();
    testArith();
    testMaskRules();
    testRestore();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule